// File: doc/BRIEF.md
# Cycle Counter with Postscaled Sampling Events

This block keeps a 32-bit count of core clock cycles. It generates a sparse stream of profiling events from that count. One of two low counter bits is watched, and every change of that bit in either direction is a tap. Each tap either steps a 4-bit down-counter or, when that down-counter is already zero, fires one event and reloads the down-counter from a programmed preset. A fired event becomes a PC-sample request or a cycle-count event request. A PC-sample request always takes precedence.

A second watcher looks at one of three high counter bits and produces synchronization pulses, which a trace path can use to pace its alignment packets. Software programs a control word and the count through a small write port. A read port returns the control word, the count, and a PC-sample value. The PC-sample value holds the last executed address, or all ones while the core is halted.

Top module: `cyc_event_gen`

## Requirements
- R1: With the enable bit (control bit 0) set and the core not halted, the count rises by exactly one per clock. With the enable bit clear it holds its value. A write to the count (write select 1) loads the written value, and the count is visible on the read port (read select 1) in the cycle after the write edge.
- R2: While `core_halted` is high the count does not change.
- R3: Counting up from 0xFFFFFFFF gives 0x00000000.
- R4: Control bit 1 selects the watched low bit: 0 picks count bit 6 and 1 picks count bit 10. A rising or a falling change of the selected bit while enabled is a tap, including a change caused by a count write.
- R5: A tap with a nonzero postscaler (control bits 15:12) decrements it. A tap with a zero postscaler fires an event and loads the preset (control bits 11:8). A control write loads both fields. So preset 0 fires on every tap and preset N fires on every (N+1)-th tap when the postscaler starts at zero.
- R6: With PC-sample enable (control bit 4) set, every fired event pulses `pcs_req` and `cyc_evt` stays low whatever cycle-event enable (control bit 5) holds. With bit 4 clear, a fired event pulses `cyc_evt` only if bit 5 is set.
- R7: The sync select field (control bits 3:2) is off at 0 and watches count bit 24, 26 or 28 at values 1, 2 or 3. Each change of the selected bit gives one `sync_pulse`, but only while the counter is enabled and `sync_in` is high.
- R8: `pc_sample` (also read port select 2) equals the `pc_in` value of the previous cycle. While `core_halted` is high it reads all ones.
- R9: With the counter configured as absent (`HAS_COUNTER` = 0), the enable bit reads zero after a write of one, and the count stays zero.
- R10: Each event strobe lasts one cycle per fired event, and `pcs_req` and `cyc_evt` are never high together.
- R11: After reset the control word, the count and all strobes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | Write target: 0 control word, 1 count |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read source: 0 control, 1 count, 2 PC sample, 3 zero |
| rd_data | output | 32 | Read data, combinational from the selected source |
| core_halted | input | 1 | Core is halted in debug |
| sync_in | input | 1 | External permission for synchronization pulses |
| pc_in | input | 32 | Address of the instruction executing now |
| pcs_req | output | 1 | PC-sample request strobe |
| cyc_evt | output | 1 | Cycle-count event strobe |
| sync_pulse | output | 1 | Synchronization strobe |
| pc_sample | output | 32 | Sampled PC, all ones while halted |

## Verification
A count write or an increment shows on the read port in the cycle after the clock edge that performs it. An event strobe or sync pulse comes one edge later than the count value whose bit changed, because the change is found by comparing against a copy registered on the previous edge. `pc_sample` trails `pc_in` by one edge, but the halted override is combinational. The bench drives inputs just after a falling edge and reads results at later falling edges, counting edges to match these latencies. It counts strobes over whole windows that end several cycles after the last expected tap, so every pending strobe has landed before a window closes.

// File: rtl/cyc_event_gen.sv
`timescale 1ns/1ps
module cyc_event_gen #(
  parameter bit HAS_COUNTER = 1'b1,
  parameter int CW          = 32,
  parameter int PW          = 4,
  parameter int TAP_LO      = 6,
  parameter int TAP_HI      = 10,
  parameter int SYNC_B0     = 24,
  parameter int SYNC_B1     = 26,
  parameter int SYNC_B2     = 28
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [CW-1:0] wr_data,
  input  logic [1:0]    rd_sel,
  output logic [CW-1:0] rd_data,
  input  logic          core_halted,
  input  logic          sync_in,
  input  logic [CW-1:0] pc_in,
  output logic          pcs_req,
  output logic          cyc_evt,
  output logic          sync_pulse,
  output logic [CW-1:0] pc_sample
);
  localparam int PRE_LO  = 8;
  localparam int POST_LO = PRE_LO + PW;

  logic          en_q, tap_sel_q, pcs_en_q, cyc_en_q;
  logic [1:0]    sync_sel_q;
  logic [PW-1:0] preset_q, post_q;
  logic [CW-1:0] cnt_q, pc_q, ctl_img;
  logic [1:0]    tap_prev_q;
  logic [2:0]    sync_prev_q;
  logic          pcs_req_q, cyc_evt_q, sync_q;
  logic          tap_now, tap_was, tap_hit, fire;
  logic          sync_now, sync_was, sync_hit;

  wire ctl_wr = wr_en && !wr_sel;
  wire cnt_wr = wr_en &&  wr_sel;

  assign tap_now = tap_sel_q ? cnt_q[TAP_HI]  : cnt_q[TAP_LO];
  assign tap_was = tap_sel_q ? tap_prev_q[1]  : tap_prev_q[0];
  assign tap_hit = en_q && (tap_now != tap_was);
  assign fire    = tap_hit && (post_q == '0);

  always_comb begin
    case (sync_sel_q)
      2'd1:    {sync_now, sync_was} = {cnt_q[SYNC_B0], sync_prev_q[0]};
      2'd2:    {sync_now, sync_was} = {cnt_q[SYNC_B1], sync_prev_q[1]};
      2'd3:    {sync_now, sync_was} = {cnt_q[SYNC_B2], sync_prev_q[2]};
      default: {sync_now, sync_was} = 2'b00;
    endcase
  end
  assign sync_hit = en_q && sync_in && (sync_now != sync_was);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; tap_sel_q <= 1'b0; sync_sel_q <= '0;
      pcs_en_q <= 1'b0; cyc_en_q <= 1'b0;
      preset_q <= '0; post_q <= '0;
    end else if (ctl_wr) begin
      en_q       <= HAS_COUNTER ? wr_data[0] : 1'b0;
      tap_sel_q  <= wr_data[1];
      sync_sel_q <= wr_data[3:2];
      pcs_en_q   <= wr_data[4];
      cyc_en_q   <= wr_data[5];
      preset_q   <= wr_data[PRE_LO +: PW];
      post_q     <= wr_data[POST_LO +: PW];
    end else if (tap_hit) begin
      post_q <= fire ? preset_q : post_q - 1'b1;
    end
  end

  generate
    if (HAS_COUNTER) begin : g_cnt
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    cnt_q <= '0;
        else if (cnt_wr)               cnt_q <= wr_data;
        else if (en_q && !core_halted) cnt_q <= cnt_q + 1'b1;
      end
    end else begin : g_nocnt
      assign cnt_q = '0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap_prev_q  <= '0;
      sync_prev_q <= '0;
      pcs_req_q   <= 1'b0;
      cyc_evt_q   <= 1'b0;
      sync_q      <= 1'b0;
      pc_q        <= '0;
    end else begin
      tap_prev_q  <= {cnt_q[TAP_HI], cnt_q[TAP_LO]};
      sync_prev_q <= {cnt_q[SYNC_B2], cnt_q[SYNC_B1], cnt_q[SYNC_B0]};
      pcs_req_q   <= fire && pcs_en_q;
      cyc_evt_q   <= fire && !pcs_en_q && cyc_en_q;
      sync_q      <= sync_hit;
      pc_q        <= pc_in;
    end
  end

  assign pcs_req    = pcs_req_q;
  assign cyc_evt    = cyc_evt_q;
  assign sync_pulse = sync_q;
  assign pc_sample  = core_halted ? '1 : pc_q;

  always_comb begin
    ctl_img                   = '0;
    ctl_img[0]                = en_q;
    ctl_img[1]                = tap_sel_q;
    ctl_img[3:2]              = sync_sel_q;
    ctl_img[4]                = pcs_en_q;
    ctl_img[5]                = cyc_en_q;
    ctl_img[PRE_LO +: PW]     = preset_q;
    ctl_img[POST_LO +: PW]    = post_q;
  end

  always_comb begin
    case (rd_sel)
      2'd0:    rd_data = ctl_img;
      2'd1:    rd_data = cnt_q;
      2'd2:    rd_data = pc_sample;
      default: rd_data = '0;
    endcase
  end

  // R1 and R3: one step per enabled cycle, wrapping at the top
  p_inc_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !core_halted && !cnt_wr) |=> cnt_q == $past(cnt_q) + CW'(1));

  p_halt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (core_halted && !cnt_wr) |=> $stable(cnt_q));

  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pcs_req_q || cyc_evt_q) && !$past(ctl_wr)) |-> post_q == preset_q);

  p_pcs_prio_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_evt_q |-> !$past(pcs_en_q));

  p_sync_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_q |-> $past(sync_in && en_q));

  p_halt_pc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (core_halted && rd_sel == 2'd2) |-> (&rd_data));

  p_one_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(pcs_req_q && cyc_evt_q));

  generate
    if (!HAS_COUNTER) begin : g_absent_chk
      p_absent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q && cnt_q == '0);
    end
  endgenerate
endmodule

// File: tb/test_cyc_event_gen.sv
`timescale 1ns/1ps
module test_cyc_event_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = 2'd0;
  logic        core_halted = 1'b0, sync_in = 1'b0;
  logic [31:0] pc_in = '0;
  logic [31:0] rd_data, pc_sample, rd_data_n, pc_sample_n;
  logic        pcs_req, cyc_evt, sync_pulse, pcs_n, cyc_n, sync_n;

  int total = 0, bad = 0;
  int n_pcs = 0, n_cyc = 0, n_sync = 0, n_both = 0;

  always #2.5 clk = ~clk;

  cyc_event_gen i_cyc_event_gen (
    .clk, .rst_n, .wr_en, .wr_sel, .wr_data, .rd_sel, .rd_data,
    .core_halted, .sync_in, .pc_in, .pcs_req, .cyc_evt, .sync_pulse, .pc_sample);

  cyc_event_gen #(.HAS_COUNTER(1'b0)) i_cyc_event_gen_nocnt (
    .clk, .rst_n, .wr_en, .wr_sel, .wr_data, .rd_sel, .rd_data(rd_data_n),
    .core_halted, .sync_in, .pc_in, .pcs_req(pcs_n), .cyc_evt(cyc_n),
    .sync_pulse(sync_n), .pc_sample(pc_sample_n));

  always @(negedge clk) if (rst_n) begin
    n_pcs  += int'(pcs_req);
    n_cyc  += int'(cyc_evt);
    n_sync += int'(sync_pulse);
    n_both += int'(pcs_req && cyc_evt);
  end

  // columns: tap select, preset, pc-sample en, cycle-event en, taps, exp pcs, exp cyc
  localparam int NV = 7;
  localparam int VEC [NV][7] = '{
    '{0,  0, 1, 0,  4, 4, 0},
    '{0,  1, 0, 1,  5, 0, 3},
    '{0,  3, 1, 1,  9, 3, 0},
    '{1,  0, 0, 1,  3, 0, 3},
    '{0,  2, 0, 0,  6, 0, 0},
    '{1,  1, 1, 0,  4, 2, 0},
    '{0, 15, 0, 1, 17, 0, 2}
  };

  function automatic logic [31:0] ctl(input logic en, input logic tap, input logic [1:0] sy,
                                      input logic pcs, input logic cyc,
                                      input logic [3:0] pre, input logic [3:0] post);
    return {16'h0, post, pre, 2'b00, cyc, pcs, sy, tap, en};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] v);
    rd_sel = sel;
    #1;
    v = rd_data;
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v, a;
    int bp, bc, bs;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: reset state
    rd(2'd0, v); chk("R11 ctl", v, 32'h0);
    rd(2'd1, v); chk("R11 cnt", v, 32'h0);
    chk("R11 strobes", {29'h0, pcs_req, cyc_evt, sync_pulse}, 32'h0);

    // R4 R5 R6: table walk
    for (int i = 0; i < NV; i++) begin
      int per;
      per = (VEC[i][0] != 0) ? 1024 : 64;
      wr(1'b0, ctl(0, VEC[i][0][0], 2'd0, VEC[i][2][0], VEC[i][3][0], VEC[i][1][3:0], 4'd0));
      wr(1'b1, 32'h0);
      bp = n_pcs; bc = n_cyc;
      wr(1'b0, ctl(1, VEC[i][0][0], 2'd0, VEC[i][2][0], VEC[i][3][0], VEC[i][1][3:0], 4'd0));
      repeat (per * VEC[i][4] + 4) @(negedge clk);
      wr(1'b0, 32'h0);
      repeat (4) @(negedge clk);
      chk($sformatf("R5 R6 vec%0d pcs", i), 32'(n_pcs - bp), 32'(VEC[i][5]));
      chk($sformatf("R4 R6 vec%0d cyc", i), 32'(n_cyc - bc), 32'(VEC[i][6]));
    end

    // R1: hold when disabled, count when enabled
    wr(1'b1, 32'd100);
    repeat (5) @(negedge clk);
    rd(2'd1, v); chk("R1 hold disabled", v, 32'd100);
    wr(1'b0, ctl(1, 0, 2'd0, 0, 0, 4'd0, 4'd0));
    repeat (10) @(negedge clk);
    rd(2'd1, v); chk("R1 count", v, 32'd110);

    // R9: absent counter ignores enable
    rd(2'd0, v); chk("R9 main enable readback", {31'h0, v[0]}, 32'h1);
    rd_sel = 2'd0; #1; chk("R9 absent enable", {31'h0, rd_data_n[0]}, 32'h0);
    rd_sel = 2'd1; #1; chk("R9 absent count", rd_data_n, 32'h0);

    // R2: halted holds
    @(negedge clk);
    rd(2'd1, a);
    core_halted = 1'b1;
    repeat (5) @(negedge clk);
    rd(2'd1, v); chk("R2 halted hold", v, a);
    // R8: halted PC sample
    rd(2'd2, v); chk("R8 halted read", v, 32'hFFFF_FFFF);
    chk("R8 halted port", pc_sample, 32'hFFFF_FFFF);
    core_halted = 1'b0;
    repeat (3) @(negedge clk);
    rd(2'd1, v); chk("R2 resume", v, a + 32'd3);

    // R8: one-cycle PC capture
    pc_in = 32'h1234_5678;
    @(negedge clk);
    pc_in = 32'hCAFE_0000;
    chk("R8 pc sample", pc_sample, 32'h1234_5678);
    @(negedge clk);
    rd(2'd2, v); chk("R8 pc read", v, 32'hCAFE_0000);

    // R3: wrap
    wr(1'b0, 32'h0);
    wr(1'b1, 32'hFFFF_FFFF);
    wr(1'b0, ctl(1, 0, 2'd0, 0, 0, 4'd0, 4'd0));
    rd(2'd1, v); chk("R3 before wrap", v, 32'hFFFF_FFFF);
    @(negedge clk);
    rd(2'd1, v); chk("R3 wrap", v, 32'h0);

    // R4 R10: count write that flips bit 6 is a tap; strobe lasts one cycle
    wr(1'b0, 32'h0);
    wr(1'b1, 32'h0);
    wr(1'b0, ctl(1, 0, 2'd0, 1, 1, 4'd0, 4'd0));
    wr(1'b1, 32'h40);
    chk("R4 flip no early strobe", {31'h0, pcs_req}, 32'h0);
    @(negedge clk);
    chk("R4 flip strobe", {31'h0, pcs_req}, 32'h1);
    chk("R6 flip no cyc", {31'h0, cyc_evt}, 32'h0);
    @(negedge clk);
    chk("R10 single cycle", {31'h0, pcs_req}, 32'h0);

    // R7: sync pulses
    sync_in = 1'b1;
    wr(1'b0, ctl(1, 0, 2'd1, 0, 0, 4'd0, 4'd0));
    bs = n_sync;
    wr(1'b1, 32'h00FF_FFFE);
    repeat (8) @(negedge clk);
    chk("R7 bit24 pulse", 32'(n_sync - bs), 32'd1);
    sync_in = 1'b0;
    bs = n_sync;
    wr(1'b1, 32'h00FF_FFFE);
    repeat (8) @(negedge clk);
    chk("R7 gated by sync_in", 32'(n_sync - bs), 32'd0);
    sync_in = 1'b1;
    wr(1'b0, ctl(1, 0, 2'd0, 0, 0, 4'd0, 4'd0));
    bs = n_sync;
    wr(1'b1, 32'h00FF_FFFE);
    repeat (8) @(negedge clk);
    chk("R7 select off", 32'(n_sync - bs), 32'd0);
    wr(1'b0, ctl(1, 0, 2'd3, 0, 0, 4'd0, 4'd0));
    bs = n_sync;
    wr(1'b1, 32'h0FFF_FFFE);
    repeat (8) @(negedge clk);
    chk("R7 bit28 pulse", 32'(n_sync - bs), 32'd1);

    chk("R10 never both", 32'(n_both), 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule